// File: doc/BRIEF.md
# Multi-Bank IN Endpoint Packet Buffer

This block holds outgoing packets for one device-to-host endpoint of a USB device. Its packet store is split into `NUM_BANKS` banks of `BANK_BYTES` bytes each. `BANK_BYTES` equals the endpoint's maximum packet size. The banks are used in a fixed rotation. Software pushes bytes through a valid/ready write stream into the bank currently being filled. When the final byte of a bank is written, that bank becomes ready for transmission on its own. A shorter packet, or a packet with no data at all, is closed by pulsing the ready-set strobe.

The USB engine side pulls ready packets through a second valid/ready stream. Packets leave strictly in the order in which their banks were filled. A bank that has been fully streamed stays occupied until the host's handshake is reported on `usb_ack`; only then is it freed. A busy-bank count tells software how much room is left.

An interrupt output reports that every bank is free. It is gated by an enable bit that one strobe sets and another strobe clears. Isochronous mode turns the rotation off, so that only bank 0 is used. `cfg_iso` may change only while every bank is free.

Back-pressure rules:
- On the read stream, a beat transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and the beat contents are held.
- On the write stream, `wr_ready` shows that the bank being filled is free. A byte offered while `wr_ready` is low is not held off: it is discarded and flagged.

Top module: `inep_bank_buffer`

## Requirements
- R1: After reset `busy_count` is 0, `wr_ready` is 1, `tx_valid` is 0 and `wr_overrun` is 0. `busy_count` always equals the number of banks that are not free. `wr_ready` is 1 exactly when the bank being filled is free, so it is 0 when all banks are busy.
- R2: Accepting byte number `BANK_BYTES` of a bank marks that bank ready with length `BANK_BYTES`. The next byte goes to the next bank in the order 0, 1, …, `NUM_BANKS`-1, 0.
- R3: A pulse on `pkt_ready_set` while the filled bank is free marks it ready, with a length equal to the bytes written into it. A byte accepted in the same cycle is counted in that length. If that byte is the final one, only a single packet is closed.
- R4: A pulse on `pkt_ready_set` while the filled bank is free and empty queues a zero-length packet. It appears as one beat with `tx_zlp`=1 and `tx_last`=1.
- R5: A pulse on `pkt_ready_set` while the bank being filled is not free has no effect: `busy_count` does not change.
- R6: Packets leave in fill order, and the bytes of each packet leave in write order. `tx_last` is 1 on the final byte. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_last` and `tx_zlp` stay unchanged on the next cycle.
- R7: After its last beat is taken, a bank stays counted as busy until a `usb_ack` pulse. That pulse frees it and lowers `busy_count` by one. A `usb_ack` pulse while the oldest bank has not been fully streamed has no effect.
- R8: A byte offered with `wr_valid`=1 while `wr_ready`=0 is dropped: it is not stored and does not count toward any packet. It sets `wr_overrun`, which stays 1 until reset.
- R9: `irq` = interrupt enable AND (`busy_count` = 0). The enable is 0 after reset. `irq_en_set` sets it and `irq_en_clr` clears it, and the clear wins if both are pulsed together.
- R10: While `cfg_iso`=1 only bank 0 is used. After bank 0 is marked ready, `wr_ready` stays 0 and `busy_count` stays at most 1 until that bank is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_iso | input | 1 | Isochronous mode, single bank |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Bank being filled is free |
| wr_data | input | DATA_W | Write byte |
| pkt_ready_set | input | 1 | Close the current bank as a short or zero-length packet |
| wr_overrun | output | 1 | Sticky flag for a dropped write |
| busy_count | output | $clog2(NUM_BANKS+1) | Number of banks not free |
| tx_valid | output | 1 | Read beat available |
| tx_ready | input | 1 | Read beat taken |
| tx_data | output | DATA_W | Read byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat stands for a zero-length packet; data is meaningless |
| usb_ack | input | 1 | Host handshake, frees the oldest streamed bank |
| irq_en_set | input | 1 | Strobe that enables the interrupt |
| irq_en_clr | input | 1 | Strobe that masks the interrupt |
| irq | output | 1 | All banks free while enabled |

## Verification
The hardest state to reach is full occupancy. Every bank must be busy while the fill pointer has wrapped back onto the oldest unacknowledged bank. The ignored-strobe and dropped-byte behaviour show only there.

The bench reaches it by filling all banks with distinct byte patterns before draining any of them. While full, it offers a byte and a ready-set strobe. It then drains with a stalled `tx_ready`, acknowledging one bank at a time, and checks both the order of the packets and that the dropped byte never shows up in a later packet.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    BK_FREE  = 2'd0,
    BK_READY = 2'd1,
    BK_SENT  = 2'd2
  } bank_st_e;
endpackage

// File: rtl/inep_fill_ctrl.sv
module inep_fill_ctrl #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BYTES = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OW = $clog2(BANK_BYTES),
  localparam int LW = $clog2(BANK_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_iso,
  input  logic                 wr_valid,
  input  logic                 pkt_ready_set,
  input  logic [NUM_BANKS-1:0] bank_free,
  output logic                 wr_ready,
  output logic                 wr_accept,
  output logic [BW-1:0]        wr_bank,
  output logic [OW-1:0]        wr_off,
  output logic                 val_pulse,
  output logic [BW-1:0]        val_bank,
  output logic [LW-1:0]        val_len,
  output logic                 wr_overrun
);
  logic [BW-1:0] fill_ptr;
  logic [LW-1:0] fill_cnt;
  logic [BW-1:0] cur;
  logic [BW-1:0] nxt;
  logic          full_byte;
  logic          manual;

  // in isochronous mode the rotation is frozen on bank 0
  assign cur = cfg_iso ? '0 : fill_ptr;
  assign nxt = (cfg_iso || cur == BW'(NUM_BANKS - 1)) ? '0 : cur + 1'b1;

  assign wr_ready  = bank_free[cur];
  assign wr_accept = wr_valid && wr_ready;
  assign wr_bank   = cur;
  assign wr_off    = fill_cnt[OW-1:0];

  assign full_byte = wr_accept && (fill_cnt == LW'(BANK_BYTES - 1));
  assign manual    = pkt_ready_set && wr_ready && !full_byte;
  assign val_pulse = full_byte || manual;
  assign val_bank  = cur;

  always_comb begin
    if (full_byte) val_len = LW'(BANK_BYTES);
    else if (wr_accept) val_len = fill_cnt + 1'b1;
    else val_len = fill_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_ptr   <= '0;
      fill_cnt   <= '0;
      wr_overrun <= 1'b0;
    end else begin
      if (val_pulse) begin
        fill_cnt <= '0;
        fill_ptr <= nxt;
      end else if (wr_accept) begin
        fill_cnt <= fill_cnt + 1'b1;
      end
      if (wr_valid && !wr_ready) wr_overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/inep_bank_state.sv
module inep_bank_state
  import inep_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BYTES = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LW = $clog2(BANK_BYTES + 1),
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    val_pulse,
  input  logic [BW-1:0]           val_bank,
  input  logic [LW-1:0]           val_len,
  input  logic                    sent_pulse,
  input  logic [BW-1:0]           sent_bank,
  input  logic                    free_pulse,
  input  logic [BW-1:0]           free_bank,
  output logic [NUM_BANKS-1:0]    bank_free,
  output logic [NUM_BANKS-1:0]    bank_ready,
  output logic [NUM_BANKS-1:0]    bank_sent,
  output logic [NUM_BANKS*LW-1:0] len_flat,
  output logic [CW-1:0]           busy_count
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_st_e      st;
    logic [LW-1:0] len;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= BK_FREE;
        len <= '0;
      end else if (val_pulse && val_bank == BW'(g)) begin
        st  <= BK_READY;
        len <= val_len;
      end else if (sent_pulse && sent_bank == BW'(g)) begin
        st <= BK_SENT;
      end else if (free_pulse && free_bank == BW'(g)) begin
        st <= BK_FREE;
      end
    end

    assign bank_free[g]            = (st == BK_FREE);
    assign bank_ready[g]           = (st == BK_READY);
    assign bank_sent[g]            = (st == BK_SENT);
    assign len_flat[g*LW +: LW]    = len;
  end

  always_comb begin
    busy_count = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (!bank_free[i]) busy_count = busy_count + 1'b1;
  end
endmodule

// File: rtl/inep_bank_mem.sv
module inep_bank_mem #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OW    = $clog2(BANK_BYTES),
  localparam int DEPTH = NUM_BANKS * BANK_BYTES
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BW-1:0]     wbank,
  input  logic [OW-1:0]     woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BW-1:0]     rbank,
  input  logic [OW-1:0]     roff,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  int unsigned widx;
  int unsigned ridx;

  always_comb begin
    widx = int'(wbank) * BANK_BYTES + int'(woff);
    ridx = int'(rbank) * BANK_BYTES + int'(roff);
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/inep_drain_ctrl.sv
module inep_drain_ctrl #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BYTES = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OW = $clog2(BANK_BYTES),
  localparam int LW = $clog2(BANK_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_iso,
  input  logic [NUM_BANKS-1:0]    bank_ready,
  input  logic [NUM_BANKS-1:0]    bank_sent,
  input  logic [NUM_BANKS*LW-1:0] len_flat,
  input  logic                    tx_ready,
  input  logic                    usb_ack,
  output logic                    tx_valid,
  output logic                    tx_last,
  output logic                    tx_zlp,
  output logic [BW-1:0]           rd_bank,
  output logic [OW-1:0]           rd_off,
  output logic                    sent_pulse,
  output logic                    free_pulse
);
  logic [BW-1:0] rd_ptr;
  logic [LW-1:0] off;
  logic [LW-1:0] len;
  logic [BW-1:0] nxt;
  logic          take;

  assign rd_bank = cfg_iso ? '0 : rd_ptr;
  assign nxt     = (cfg_iso || rd_bank == BW'(NUM_BANKS - 1)) ? '0 : rd_bank + 1'b1;
  assign len     = len_flat[rd_bank*LW +: LW];

  assign tx_valid   = bank_ready[rd_bank];
  assign tx_zlp     = (len == '0);
  assign tx_last    = tx_zlp || (off == len - 1'b1);
  assign rd_off     = off[OW-1:0];
  assign take       = tx_valid && tx_ready;
  assign sent_pulse = take && tx_last;
  assign free_pulse = usb_ack && bank_sent[rd_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      off    <= '0;
    end else begin
      if (sent_pulse) off <= '0;
      else if (take) off <= off + 1'b1;
      if (free_pulse) rd_ptr <= nxt;
    end
  end
endmodule

// File: rtl/inep_bank_buffer.sv
module inep_bank_buffer #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OW = $clog2(BANK_BYTES),
  localparam int LW = $clog2(BANK_BYTES + 1),
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_iso,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_ready_set,
  output logic              wr_overrun,
  output logic [CW-1:0]     busy_count,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_zlp,
  input  logic              usb_ack,
  input  logic              irq_en_set,
  input  logic              irq_en_clr,
  output logic              irq
);
  logic [NUM_BANKS-1:0]    bank_free;
  logic [NUM_BANKS-1:0]    bank_ready;
  logic [NUM_BANKS-1:0]    bank_sent;
  logic [NUM_BANKS*LW-1:0] len_flat;
  logic                    wr_accept;
  logic [BW-1:0]           wr_bank;
  logic [OW-1:0]           wr_off;
  logic                    val_pulse;
  logic [BW-1:0]           val_bank;
  logic [LW-1:0]           val_len;
  logic [BW-1:0]           rd_bank;
  logic [OW-1:0]           rd_off;
  logic                    sent_pulse;
  logic                    free_pulse;
  logic                    irq_en;

  inep_fill_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) fill_i (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso),
    .wr_valid(wr_valid), .pkt_ready_set(pkt_ready_set), .bank_free(bank_free),
    .wr_ready(wr_ready), .wr_accept(wr_accept), .wr_bank(wr_bank), .wr_off(wr_off),
    .val_pulse(val_pulse), .val_bank(val_bank), .val_len(val_len),
    .wr_overrun(wr_overrun)
  );

  inep_bank_state #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) state_i (
    .clk(clk), .rst_n(rst_n),
    .val_pulse(val_pulse), .val_bank(val_bank), .val_len(val_len),
    .sent_pulse(sent_pulse), .sent_bank(rd_bank),
    .free_pulse(free_pulse), .free_bank(rd_bank),
    .bank_free(bank_free), .bank_ready(bank_ready), .bank_sent(bank_sent),
    .len_flat(len_flat), .busy_count(busy_count)
  );

  inep_bank_mem #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .we(wr_accept), .wbank(wr_bank), .woff(wr_off), .wdata(wr_data),
    .rbank(rd_bank), .roff(rd_off), .rdata(tx_data)
  );

  inep_drain_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES)) drain_i (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso),
    .bank_ready(bank_ready), .bank_sent(bank_sent), .len_flat(len_flat),
    .tx_ready(tx_ready), .usb_ack(usb_ack),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp),
    .rd_bank(rd_bank), .rd_off(rd_off),
    .sent_pulse(sent_pulse), .free_pulse(free_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_en <= 1'b0;
    else if (irq_en_clr) irq_en <= 1'b0;
    else if (irq_en_set) irq_en <= 1'b1;
  end

  assign irq = irq_en && (busy_count == '0);
endmodule

// File: rtl/inep_bank_buffer_chk.sv
module inep_bank_buffer_chk #(
  parameter int NUM_BANKS = 3,
  parameter int DATA_W    = 8,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_iso,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              pkt_ready_set,
  input logic              wr_overrun,
  input logic [CW-1:0]     busy_count,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_last,
  input logic              tx_zlp,
  input logic              usb_ack,
  input logic              irq_en_set,
  input logic              irq_en_clr,
  input logic              irq
);
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_count == CW'(NUM_BANKS)) |-> !wr_ready); // R1

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready_set && !wr_ready && !tx_valid && !usb_ack) |=> $stable(busy_count)); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp))); // R6

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_overrun); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overrun |=> wr_overrun); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_clr |=> !irq); // R9

  AST_ISO_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_iso && $stable(cfg_iso)) |-> (busy_count <= CW'(1))); // R10
endmodule

bind inep_bank_buffer inep_bank_buffer_chk #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .pkt_ready_set(pkt_ready_set), .wr_overrun(wr_overrun), .busy_count(busy_count),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .tx_zlp(tx_zlp), .usb_ack(usb_ack), .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
  .irq(irq)
);

// File: tb/inep_bank_buffer_tb_top.sv
`timescale 1ns/1ps
module inep_bank_buffer_tb_top;
  localparam int NB = 3;
  localparam int BB = 8;
  localparam int DW = 8;
  localparam int CW = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_iso = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          pkt_ready_set = 1'b0;
  logic          wr_overrun;
  logic [CW-1:0] busy_count;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic          tx_last;
  logic          tx_zlp;
  logic          usb_ack = 1'b0;
  logic          irq_en_set = 1'b0;
  logic          irq_en_clr = 1'b0;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  inep_bank_buffer #(.NUM_BANKS(NB), .BANK_BYTES(BB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pkt_ready_set(pkt_ready_set), .wr_overrun(wr_overrun),
    .busy_count(busy_count), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_zlp(tx_zlp), .usb_ack(usb_ack), .irq_en_set(irq_en_set),
    .irq_en_clr(irq_en_clr), .irq(irq)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    pkt_ready_set = 1'b1;
    @(posedge clk);
    #1 pkt_ready_set = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    usb_ack = 1'b1;
    @(posedge clk);
    #1 usb_ack = 1'b0;
  endtask

  // receive n bytes base, base+1, ... ; n==0 expects a zero-length beat
  task automatic recv(input int n, input logic [DW-1:0] base, input string req);
    int beats = (n == 0) ? 1 : n;
    for (int i = 0; i < beats; i++) begin
      int wait_c = 0;
      @(negedge clk);
      while (!tx_valid && wait_c < 50) begin
        @(negedge clk);
        wait_c++;
      end
      check(tx_valid, req, tx_valid, 1);
      if (n == 0) begin
        check(tx_zlp && tx_last, req, {tx_zlp, tx_last}, 3);
      end else begin
        check(tx_data == base + DW'(i), req, tx_data, base + DW'(i));
        check(tx_last == (i == n - 1), req, tx_last, (i == n - 1));
      end
      tx_ready = 1'b1;
      @(posedge clk);
      #1 tx_ready = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy_count == 0, "R1 reset busy", busy_count, 0);
    check(wr_ready == 1'b1, "R1 reset wr_ready", wr_ready, 1);
    check(tx_valid == 1'b0, "R1 reset tx_valid", tx_valid, 0);
    check(wr_overrun == 1'b0, "R1 reset overrun", wr_overrun, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);
  endtask

  task automatic t_full_packet();
    for (int i = 0; i < BB; i++) push(8'h10 + 8'(i));
    @(negedge clk);
    check(busy_count == 1, "R2 auto ready", busy_count, 1);
    recv(BB, 8'h10, "R6 full packet");
    @(negedge clk);
    check(busy_count == 1, "R7 busy until ack", busy_count, 1);
    ack();
    @(negedge clk);
    check(busy_count == 0, "R7 ack frees", busy_count, 0);
  endtask

  task automatic t_short_packet();
    push(8'h20); push(8'h21);
    // third byte together with the strobe is counted in the length
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h22; pkt_ready_set = 1'b1;
    @(posedge clk);
    #1 wr_valid = 1'b0; pkt_ready_set = 1'b0;
    @(negedge clk);
    check(busy_count == 1, "R3 short ready", busy_count, 1);
    recv(3, 8'h20, "R3 short packet");
    ack();
  endtask

  task automatic t_zlp();
    strobe();
    @(negedge clk);
    check(busy_count == 1, "R4 zlp queued", busy_count, 1);
    recv(0, 8'h00, "R4 zlp beat");
    ack();
    @(negedge clk);
    check(busy_count == 0, "R4 zlp freed", busy_count, 0);
  endtask

  task automatic t_fill_all();
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < BB; i++) push(8'h40 + 8'(b * 16 + i));
    @(negedge clk);
    check(busy_count == NB, "R2 all banks busy", busy_count, NB);
    check(wr_ready == 1'b0, "R1 full not ready", wr_ready, 0);
    push(8'hEE);
    @(negedge clk);
    check(wr_overrun == 1'b1, "R8 overrun set", wr_overrun, 1);
    strobe();
    @(negedge clk);
    check(busy_count == NB, "R5 strobe ignored", busy_count, NB);
    // stall the read side, data must hold
    begin
      logic [DW-1:0] held = tx_data;
      @(negedge clk);
      check(tx_valid && tx_data == held, "R6 stall hold", tx_data, held);
    end
    for (int b = 0; b < NB; b++) begin
      recv(BB, 8'h40 + 8'(b * 16), "R6 fill order");
      ack();
      @(negedge clk);
      check(busy_count == CW'(NB - 1 - b), "R7 ack count", busy_count, NB - 1 - b);
    end
    check(wr_overrun == 1'b1, "R8 overrun sticky", wr_overrun, 1);
  endtask

  task automatic t_irq();
    @(negedge clk);
    irq_en_set = 1'b1;
    @(posedge clk);
    #1 irq_en_set = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R9 irq all free", irq, 1);
    for (int i = 0; i < BB; i++) push(8'h80 + 8'(i));
    @(negedge clk);
    check(irq == 1'b0, "R9 irq busy", irq, 0);
    recv(BB, 8'h80, "R8 dropped byte absent");
    ack();
    @(negedge clk);
    check(irq == 1'b1, "R9 irq after ack", irq, 1);
    irq_en_set = 1'b1; irq_en_clr = 1'b1;
    @(posedge clk);
    #1 irq_en_set = 1'b0; irq_en_clr = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R9 clear wins", irq, 0);
  endtask

  task automatic t_early_ack();
    ack();
    @(negedge clk);
    check(busy_count == 0, "R7 ack idle ignored", busy_count, 0);
    push(8'h90);
    strobe();
    ack();
    @(negedge clk);
    check(busy_count == 1, "R7 ack before send ignored", busy_count, 1);
    recv(1, 8'h90, "R7 single byte");
    ack();
    @(negedge clk);
    check(busy_count == 0, "R7 freed", busy_count, 0);
  endtask

  task automatic t_iso();
    @(negedge clk);
    cfg_iso = 1'b1;
    for (int i = 0; i < BB; i++) push(8'hA0 + 8'(i));
    @(negedge clk);
    check(busy_count == 1, "R10 iso one busy", busy_count, 1);
    check(wr_ready == 1'b0, "R10 iso not ready", wr_ready, 0);
    recv(BB, 8'hA0, "R10 iso data");
    @(negedge clk);
    check(wr_ready == 1'b0, "R10 iso wait ack", wr_ready, 0);
    ack();
    @(negedge clk);
    check(wr_ready == 1'b1 && busy_count == 0, "R10 iso freed", busy_count, 0);
    for (int i = 0; i < BB; i++) push(8'hB0 + 8'(i));
    recv(BB, 8'hB0, "R10 iso reuse bank");
    ack();
    @(negedge clk);
    cfg_iso = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full_packet();
    t_short_packet();
    t_zlp();
    t_fill_all();
    t_irq();
    t_early_ack();
    t_iso();
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule